// File: doc/BRIEF.md
# Microcontroller Status Register with Wake Flags

This block is the 8-bit status register of a small RISC microcontroller core. It keeps the three ALU result flags (carry, half carry, zero) and two reset-cause bits that software reads after a reset or a wake-up to learn what happened: a power-down bit and a time-out bit. It also holds three bank-select bits, one for the data-register page and two that together select one of three control-register pages.

The ALU updates the flags through per-flag write enables. Software can write the whole byte, but the two reset-cause bits ignore such writes. One-cycle strobes report these events: sleep entry, watchdog clear, watchdog timeout (with a level input saying whether the core was asleep), power-up, external-reset wake-up from sleep and external reset while awake. The register drives its value, a decoded control-page index and the data-page bit.

Top module: `mcu_status_reg`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) or a `ev_pwr_up` strobe, `status` reads 8'h18: time-out (bit 4) = 1, power-down (bit 3) = 1, all other bits 0. `ctl_page` and `data_page` read 0.
- R2: For each flag bit i in 0..2 (carry = bit 0, half carry = bit 1, zero = bit 2), `alu_we[i]` = 1 loads `alu_flags[i]` into bit i at the next edge. A flag whose enable is 0 keeps its value.
- R3: A software write (`sw_we` = 1) loads `sw_data` into bits 0, 1, 2, 5, 6 and 7. Bits 3 and 4 are unaffected.
- R4: When a software write and an ALU update occur in the same cycle, each enabled flag bit takes `alu_flags` and each non-enabled flag bit takes `sw_data`.
- R5: `ev_sleep` sets time-out = 1 and power-down = 0. `ev_wdt_clr` sets time-out = 1 and power-down = 1. Neither changes any other bit.
- R6: `ev_wdt_to` with `core_asleep` = 1 gives time-out = 0, power-down = 0. With `core_asleep` = 0 it gives time-out = 0, power-down = 1. In both cases bits 5 to 7 clear and the flags keep their values.
- R7: `ev_ext_wake` gives time-out = 1, power-down = 0 and clears bits 5 to 7. `ev_ext_rst` leaves time-out and power-down unchanged and clears bits 5 to 7. Both keep the flags.
- R8: When strobes coincide, only the highest one takes effect. The order, highest first, is `ev_pwr_up`, `ev_wdt_to`, `ev_ext_wake`, `ev_ext_rst`, `ev_sleep`, `ev_wdt_clr`.
- R9: `ctl_page` = 0 whenever bit 5 = 0, whatever bit 6 holds. It is 1 when bit 5 = 1 and bit 6 = 0, and 2 when both bits are 1. It never reads 3.
- R10: `data_page` equals bit 7 of `status`.
- R11: In a cycle that carries a reset-type event (power-up, watchdog timeout, external wake or external reset), software writes and ALU updates are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, same effect as power-up |
| alu_we | input | 3 | Per-flag write enables (bit 0 carry, 1 half carry, 2 zero) |
| alu_flags | input | 3 | New flag values from the ALU |
| sw_we | input | 1 | Software byte write strobe |
| sw_data | input | 8 | Software write data |
| ev_sleep | input | 1 | Sleep instruction executed |
| ev_wdt_clr | input | 1 | Watchdog-clear instruction executed |
| ev_wdt_to | input | 1 | Watchdog timed out |
| core_asleep | input | 1 | Core is in sleep mode (qualifies `ev_wdt_to`) |
| ev_pwr_up | input | 1 | Power-up event |
| ev_ext_wake | input | 1 | External reset woke the core from sleep |
| ev_ext_rst | input | 1 | External reset while awake |
| status | output | 8 | Register value |
| ctl_page | output | 2 | Control-register page index 0, 1 or 2 |
| data_page | output | 1 | Data-register page bit |

## Verification
Each event is applied starting from known time-out and power-down values. A sleep entry followed by a watchdog timeout asleep gives a different pair from a timeout while awake, and an external wake gives a different pair from an external reset while awake. Software writes of 8'h00, 8'hE7 and 8'h18 show that the two reset-cause bits hold in both directions while the writable bits move. The page patterns 8'hA0, 8'hE0 and 8'h40 separate page 1, page 2 and the case where bit 6 is ignored. Combined strobes, and combined write and ALU cycles, confirm the priority order and the per-bit merge.

// File: rtl/mcu_status_pkg.sv
// Package: shared bit positions, field widths and the event kind used by the
// status register and its sub-blocks. Assumes an 8-bit register layout.
package mcu_status_pkg;

    localparam int REG_W      = 8;
    localparam int FLAG_W     = 3;
    localparam int PAGE_W     = 3;

    localparam int BIT_CARRY  = 0;
    localparam int BIT_HALF   = 1;
    localparam int BIT_ZERO   = 2;
    localparam int BIT_PD     = 3;
    localparam int BIT_TO     = 4;
    localparam int BIT_CPEN   = 5;
    localparam int BIT_CPSEL  = 6;
    localparam int BIT_DPAGE  = 7;

    localparam int PAGE_LSB   = BIT_CPEN;

    // Event that wins arbitration in one cycle.
    typedef enum logic [2:0] {
        EVK_NONE      = 3'd0,
        EVK_POWER     = 3'd1,
        EVK_WDT_SLEEP = 3'd2,
        EVK_WDT_AWAKE = 3'd3,
        EVK_EXT_WAKE  = 3'd4,
        EVK_EXT_RST   = 3'd5,
        EVK_SLEEP     = 3'd6,
        EVK_WDT_CLR   = 3'd7
    } ev_kind_e;

    // Effects of the winning event on the register.
    typedef struct packed {
        logic to_next;
        logic pd_next;
        logic page_clr;
        logic flag_clr;
        logic wr_block;
    } ev_effect_t;

endpackage

// File: rtl/sr_event_arb.sv
// Event arbiter: picks one event from the strobes by fixed priority.
// The order is power-up, watchdog timeout, external wake, external
// reset, sleep, watchdog clear. Assumes the strobes are one cycle long.
module sr_event_arb
    import mcu_status_pkg::*;
(
    input  logic     pwr_up,
    input  logic     wdt_to,
    input  logic     asleep,
    input  logic     ext_wake,
    input  logic     ext_rst,
    input  logic     sleep_in,
    input  logic     wdt_clr,
    output ev_kind_e kind
);

    // Purpose: priority chain, highest first.
    always_comb begin
        if (pwr_up)        kind = EVK_POWER;
        else if (wdt_to)   kind = asleep ? EVK_WDT_SLEEP : EVK_WDT_AWAKE;
        else if (ext_wake) kind = EVK_EXT_WAKE;
        else if (ext_rst)  kind = EVK_EXT_RST;
        else if (sleep_in) kind = EVK_SLEEP;
        else if (wdt_clr)  kind = EVK_WDT_CLR;
        else               kind = EVK_NONE;
    end

endmodule

// File: rtl/sr_cause_rules.sv
// Reset-cause rules: maps the winning event and the present time-out and
// power-down bits to their next values. It also says whether the page bits
// clear, whether the flags clear, and whether writes are blocked this cycle.
module sr_cause_rules
    import mcu_status_pkg::*;
(
    input  ev_kind_e   kind,
    input  logic       to_q,
    input  logic       pd_q,
    output ev_effect_t eff
);

    // Purpose: table of event effects; unlisted fields hold.
    always_comb begin
        eff.to_next  = to_q;
        eff.pd_next  = pd_q;
        eff.page_clr = 1'b0;
        eff.flag_clr = 1'b0;
        eff.wr_block = 1'b0;
        case (kind)
            EVK_POWER: begin
                eff.to_next  = 1'b1;
                eff.pd_next  = 1'b1;
                eff.page_clr = 1'b1;
                eff.flag_clr = 1'b1;
                eff.wr_block = 1'b1;
            end
            EVK_WDT_SLEEP: begin
                eff.to_next  = 1'b0;
                eff.pd_next  = 1'b0;
                eff.page_clr = 1'b1;
                eff.wr_block = 1'b1;
            end
            EVK_WDT_AWAKE: begin
                eff.to_next  = 1'b0;
                eff.pd_next  = 1'b1;
                eff.page_clr = 1'b1;
                eff.wr_block = 1'b1;
            end
            EVK_EXT_WAKE: begin
                eff.to_next  = 1'b1;
                eff.pd_next  = 1'b0;
                eff.page_clr = 1'b1;
                eff.wr_block = 1'b1;
            end
            EVK_EXT_RST: begin
                eff.page_clr = 1'b1;
                eff.wr_block = 1'b1;
            end
            EVK_SLEEP: begin
                eff.to_next  = 1'b1;
                eff.pd_next  = 1'b0;
            end
            EVK_WDT_CLR: begin
                eff.to_next  = 1'b1;
                eff.pd_next  = 1'b1;
            end
            default: begin
                eff.to_next  = to_q;
                eff.pd_next  = pd_q;
            end
        endcase
    end

endmodule

// File: rtl/sr_field_upd.sv
// Field updater: next value of an N-bit writable field. Clear beats
// block, block beats the writers, and an ALU enable beats a software
// write bit by bit. When HAS_ALU is 0, the ALU path is not built.
module sr_field_upd #(
    parameter int N       = 3,
    parameter bit HAS_ALU = 1'b1
) (
    input  logic         clr,
    input  logic         block,
    input  logic [N-1:0] alu_we,
    input  logic [N-1:0] alu_d,
    input  logic         sw_we,
    input  logic [N-1:0] sw_d,
    input  logic [N-1:0] cur,
    output logic [N-1:0] nxt
);

    logic [N-1:0] alu_en;

    generate
        if (HAS_ALU) begin : g_alu
            assign alu_en = alu_we;
        end else begin : g_noalu
            logic [N-1:0] unused_alu;
            assign unused_alu = alu_we ^ alu_d;
            assign alu_en     = '0;
        end
    endgenerate

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Purpose: select the next value of one bit.
        always_comb begin
            if (clr)            nxt[i] = 1'b0;
            else if (block)     nxt[i] = cur[i];
            else if (alu_en[i]) nxt[i] = alu_d[i];
            else if (sw_we)     nxt[i] = sw_d[i];
            else                nxt[i] = cur[i];
        end
    end

endmodule

// File: rtl/sr_page_dec.sv
// Page decoder: turns the enable and select bits into a control-page index
// (0, 1 or 2). The select bit is ignored while the enable bit is 0.
module sr_page_dec #(
    parameter int IDX_W = 2
) (
    input  logic             en,
    input  logic             sel,
    output logic [IDX_W-1:0] idx
);

    // Purpose: three-way decode.
    always_comb begin
        if (!en)      idx = IDX_W'(0);
        else if (sel) idx = IDX_W'(2);
        else          idx = IDX_W'(1);
    end

endmodule

// File: rtl/mcu_status_reg.sv
// Top: microcontroller status register. It holds the ALU flags, the
// time-out and power-down cause bits and the page-select bits. It assumes
// one-cycle event strobes and a synchronous active-low reset that acts
// as power-up.
module mcu_status_reg
    import mcu_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] alu_we,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic              sw_we,
    input  logic [REG_W-1:0]  sw_data,
    input  logic              ev_sleep,
    input  logic              ev_wdt_clr,
    input  logic              ev_wdt_to,
    input  logic              core_asleep,
    input  logic              ev_pwr_up,
    input  logic              ev_ext_wake,
    input  logic              ev_ext_rst,
    output logic [REG_W-1:0]  status,
    output logic [1:0]        ctl_page,
    output logic              data_page
);

    localparam logic [REG_W-1:0] RST_VAL =
        REG_W'((1 << BIT_TO) | (1 << BIT_PD));

    logic [REG_W-1:0]  stat_q;
    logic [REG_W-1:0]  stat_d;
    ev_kind_e          kind;
    ev_effect_t        eff;
    logic [FLAG_W-1:0] flag_nxt;
    logic [PAGE_W-1:0] page_nxt;

    sr_event_arb u_arb (
        .pwr_up   (ev_pwr_up),
        .wdt_to   (ev_wdt_to),
        .asleep   (core_asleep),
        .ext_wake (ev_ext_wake),
        .ext_rst  (ev_ext_rst),
        .sleep_in (ev_sleep),
        .wdt_clr  (ev_wdt_clr),
        .kind     (kind)
    );

    sr_cause_rules u_rules (
        .kind (kind),
        .to_q (stat_q[BIT_TO]),
        .pd_q (stat_q[BIT_PD]),
        .eff  (eff)
    );

    sr_field_upd #(.N(FLAG_W), .HAS_ALU(1'b1)) u_flags (
        .clr    (eff.flag_clr),
        .block  (eff.wr_block),
        .alu_we (alu_we),
        .alu_d  (alu_flags),
        .sw_we  (sw_we),
        .sw_d   (sw_data[FLAG_W-1:0]),
        .cur    (stat_q[FLAG_W-1:0]),
        .nxt    (flag_nxt)
    );

    sr_field_upd #(.N(PAGE_W), .HAS_ALU(1'b0)) u_pages (
        .clr    (eff.page_clr),
        .block  (eff.wr_block),
        .alu_we ('0),
        .alu_d  ('0),
        .sw_we  (sw_we),
        .sw_d   (sw_data[PAGE_LSB +: PAGE_W]),
        .cur    (stat_q[PAGE_LSB +: PAGE_W]),
        .nxt    (page_nxt)
    );

    sr_page_dec #(.IDX_W(2)) u_pdec (
        .en  (stat_q[BIT_CPEN]),
        .sel (stat_q[BIT_CPSEL]),
        .idx (ctl_page)
    );

    // Purpose: assemble the next register value from its fields.
    always_comb begin
        stat_d                        = stat_q;
        stat_d[FLAG_W-1:0]            = flag_nxt;
        stat_d[BIT_PD]                = eff.pd_next;
        stat_d[BIT_TO]                = eff.to_next;
        stat_d[PAGE_LSB +: PAGE_W]    = page_nxt;
    end

    // Purpose: state register with synchronous reset to the power-up value.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= RST_VAL;
        else        stat_q <= stat_d;
    end

    assign status    = stat_q;
    assign data_page = stat_q[BIT_DPAGE];

endmodule

// File: rtl/mcu_status_reg_chk.sv
// Checker: clocked properties on the status register's ports, attached by
// bind. Assumes the port meanings given in the brief.
module mcu_status_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_we,
    input logic       ev_sleep,
    input logic       ev_wdt_clr,
    input logic       ev_wdt_to,
    input logic       core_asleep,
    input logic       ev_pwr_up,
    input logic       ev_ext_wake,
    input logic       ev_ext_rst,
    input logic [7:0] status,
    input logic [1:0] ctl_page,
    input logic       data_page
);

    logic any_rst_ev;
    logic any_ev;
    assign any_rst_ev = ev_pwr_up | ev_wdt_to | ev_ext_wake | ev_ext_rst;
    assign any_ev     = any_rst_ev | ev_sleep | ev_wdt_clr;

    a_r1_power_value: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pwr_up |=> status == 8'h18);

    a_r3_cause_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !any_ev) |=> $stable(status[4:3]));

    a_r5_sleep_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sleep && !any_rst_ev) |=> (status[4] && !status[3]));

    a_r5_wdtclr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt_clr && !any_rst_ev && !ev_sleep) |=> (status[4] && status[3]));

    a_r6_wdt_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt_to && core_asleep && !ev_pwr_up) |=> (status[7:3] == 5'b0));

    a_r6_wdt_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt_to && !core_asleep && !ev_pwr_up) |=> (status[7:3] == 5'b00001));

    a_r7_ext_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ext_rst && !ev_pwr_up && !ev_wdt_to && !ev_ext_wake)
        |=> (status[7:5] == 3'b0 && $stable(status[4:0])));

    a_r9_no_page3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_page != 2'd3);

    a_r9_page0: assert property (@(posedge clk) disable iff (!rst_n)
        !status[5] |-> ctl_page == 2'd0);

    a_r10_dpage: assert property (@(posedge clk) disable iff (!rst_n)
        data_page == status[7]);

endmodule

bind mcu_status_reg mcu_status_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_we       (sw_we),
    .ev_sleep    (ev_sleep),
    .ev_wdt_clr  (ev_wdt_clr),
    .ev_wdt_to   (ev_wdt_to),
    .core_asleep (core_asleep),
    .ev_pwr_up   (ev_pwr_up),
    .ev_ext_wake (ev_ext_wake),
    .ev_ext_rst  (ev_ext_rst),
    .status      (status),
    .ctl_page    (ctl_page),
    .data_page   (data_page)
);

// File: tb/mcu_status_reg_tb_top.sv
// Directed bench: one task per scenario. Inputs change on the falling edge,
// and results are sampled 1 ns after the rising edge.
module mcu_status_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] alu_we = '0;
    logic [2:0] alu_flags = '0;
    logic       sw_we = 1'b0;
    logic [7:0] sw_data = '0;
    logic       ev_sleep = 1'b0, ev_wdt_clr = 1'b0, ev_wdt_to = 1'b0;
    logic       core_asleep = 1'b0, ev_pwr_up = 1'b0;
    logic       ev_ext_wake = 1'b0, ev_ext_rst = 1'b0;
    logic [7:0] status;
    logic [1:0] ctl_page;
    logic       data_page;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mcu_status_reg dut_i (
        .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_flags(alu_flags),
        .sw_we(sw_we), .sw_data(sw_data), .ev_sleep(ev_sleep),
        .ev_wdt_clr(ev_wdt_clr), .ev_wdt_to(ev_wdt_to),
        .core_asleep(core_asleep), .ev_pwr_up(ev_pwr_up),
        .ev_ext_wake(ev_ext_wake), .ev_ext_rst(ev_ext_rst),
        .status(status), .ctl_page(ctl_page), .data_page(data_page)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alu_we = '0; alu_flags = '0; sw_we = 1'b0; sw_data = '0;
        ev_sleep = 1'b0; ev_wdt_clr = 1'b0; ev_wdt_to = 1'b0;
        core_asleep = 1'b0; ev_pwr_up = 1'b0;
        ev_ext_wake = 1'b0; ev_ext_rst = 1'b0;
    endtask

    // Apply the prepared inputs for one edge, then sample.
    task automatic step();
        @(posedge clk); #1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic sw_write(input logic [7:0] d);
        sw_we = 1'b1; sw_data = d;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset value", status, 8'h18);
        chk("R1 reset ctl_page", {6'b0, ctl_page}, 8'h00);
        chk("R1 reset data_page", {7'b0, data_page}, 8'h00);
    endtask

    task automatic t_alu();
        alu_we = 3'b101; alu_flags = 3'b111;
        step();
        chk("R2 alu enabled bits only", status, 8'h1D);
    endtask

    task automatic t_sw_pages();
        sw_write(8'h00);
        chk("R3 write zero keeps cause bits", status, 8'h18);
        sw_write(8'hE7);
        chk("R3 write writable bits", status, 8'hFF);
        sw_write(8'hA0);
        chk("R9 page 1", {6'b0, ctl_page}, 8'h01);
        chk("R10 data page set", {7'b0, data_page}, 8'h01);
        sw_write(8'hE0);
        chk("R9 page 2", {6'b0, ctl_page}, 8'h02);
        sw_write(8'h40);
        chk("R9 select ignored when enable low", {6'b0, ctl_page}, 8'h00);
        chk("R10 data page clear", {7'b0, data_page}, 8'h00);
        chk("R3 value after 0x40", status, 8'h58);
    endtask

    task automatic t_alu_vs_sw();
        sw_we = 1'b1; sw_data = 8'h07; alu_we = 3'b011; alu_flags = 3'b000;
        step();
        chk("R4 per-bit merge", status, 8'h1C);
    endtask

    task automatic t_sleep_clr();
        ev_sleep = 1'b1;
        step();
        chk("R5 sleep entry", status, 8'h14);
        sw_write(8'h18);
        chk("R3 cannot set cause bits", status, 8'h10);
        ev_wdt_clr = 1'b1;
        step();
        chk("R5 watchdog clear", status, 8'h18);
    endtask

    task automatic t_wdt();
        sw_write(8'hE1);
        ev_wdt_to = 1'b1; core_asleep = 1'b0;
        step();
        chk("R6 timeout awake", status, 8'h09);
        ev_wdt_to = 1'b1; core_asleep = 1'b1;
        step();
        chk("R6 timeout asleep after awake", status, 8'h01);
        ev_sleep = 1'b1;
        step();
        ev_wdt_to = 1'b1; core_asleep = 1'b1;
        step();
        chk("R6 timeout asleep", status, 8'h01);
    endtask

    task automatic t_ext();
        sw_write(8'hE1);
        ev_ext_wake = 1'b1;
        step();
        chk("R7 external wake", status, 8'h11);
        sw_write(8'hA3);
        ev_ext_rst = 1'b1;
        step();
        chk("R7 external reset awake", status, 8'h13);
    endtask

    task automatic t_prio();
        ev_pwr_up = 1'b1; ev_wdt_to = 1'b1; ev_sleep = 1'b1; ev_wdt_clr = 1'b1;
        ev_ext_wake = 1'b1; ev_ext_rst = 1'b1; sw_we = 1'b1; sw_data = 8'hFF;
        alu_we = 3'b111; alu_flags = 3'b111;
        step();
        chk("R8 power-up wins", status, 8'h18);
        ev_sleep = 1'b1;
        step();
        ev_wdt_to = 1'b1; core_asleep = 1'b1; ev_sleep = 1'b1; ev_wdt_clr = 1'b1;
        ev_ext_wake = 1'b1;
        step();
        chk("R8 timeout over wake and sleep", status, 8'h00);
        ev_ext_wake = 1'b1; ev_ext_rst = 1'b1; ev_sleep = 1'b1; ev_wdt_clr = 1'b1;
        step();
        chk("R8 wake over the rest", status, 8'h10);
        ev_ext_rst = 1'b1; ev_wdt_clr = 1'b1;
        step();
        chk("R8 ext reset over watchdog clear", status, 8'h10);
        ev_wdt_clr = 1'b1;
        step();
        ev_sleep = 1'b1; ev_wdt_clr = 1'b1;
        step();
        chk("R8 sleep over watchdog clear", status, 8'h10);
    endtask

    task automatic t_block();
        ev_ext_rst = 1'b1; sw_we = 1'b1; sw_data = 8'hE7;
        alu_we = 3'b111; alu_flags = 3'b111;
        step();
        chk("R11 writes ignored on reset event", status, 8'h10);
        sw_write(8'hE7);
        ev_pwr_up = 1'b1;
        step();
        chk("R1 power-up strobe mid-run", status, 8'h18);
    endtask

    initial begin
        idle_inputs();
        @(negedge clk);
        t_reset();
        t_alu();
        t_sw_pages();
        t_alu_vs_sw();
        t_sleep_clr();
        t_wdt();
        t_ext();
        t_prio();
        t_block();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule